// File: doc/BRIEF.md
# Direction-Aware Timer Output Control

This block keeps the output lines of a configurable timer and updates them from per-line set and clear requests that an event engine supplies. Each line has a two-bit steering field. It picks whether set and clear keep their meaning or trade places while a chosen counter counts down. This lets one event program produce a symmetric waveform in a counter that runs up and then down. The counters and the event logic live outside the block. The block only sees their down-count and halt flags and a unify flag, which says the two counters are running as one wide counter.

A small register bus reaches two words. Word 0 is the line-level register. It can be read at any time. A write to it is accepted only while both counters are halted. A write made while either counter is running is dropped and flagged with a bus error in the same cycle. Word 1 holds the steering fields, and a write to it is always accepted. Each steering field decodes to one of four modes:
- NONE never swaps.
- LOW swaps while the low counter or the unified counter counts down.
- HIGH swaps while the high counter counts down.
- RESERVED never swaps.

Top module: `tmr_outctl`

## Requirements
- R1: After reset every output line is 0, and both word 0 and word 1 read as all zeros.
- R2: With steering field 0, a set request for line n drives it to 1 and a clear request drives it to 0. The new level is visible one clock after the request is sampled. A line with no request keeps its level.
- R3: With steering field 1, set and clear trade places while `lo_down` is 1, whatever the value of `unify`.
- R4: With steering field 2 and `unify` at 0, set and clear trade places while `hi_down` is 1.
- R5: Field value 3, and field value 2 while `unify` is 1, act as field 0: set and clear never trade places.
- R6: When set and clear for the same line are both active in one cycle, after any swap, the line toggles on the next clock.
- R7: A write to word 0 (`bus_addr` = 0) while `lo_halt` and `hi_halt` are both 1 loads line n from `bus_wdata[n]` on the next clock. It takes priority over every set and clear request in that cycle, and `bus_err` stays 0.
- R8: A write to word 0 while either halt flag is 0 drives `bus_err` to 1 in the same cycle and does not change any line.
- R9: A read of word 0 returns the current line levels in bits 15:0 and zeros in bits 31:16, in any counter state.
- R10: Word 1 (`bus_addr` = 1) is written on every write. It reads back the steering field for line n at bits 2n+1:2n.
- R11: Reads of addresses 2 and 3 return 0. Writes to them change nothing and raise no error. `bus_rdata` is 0 when `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_set | input | 16 | Per-line set requests |
| ev_clr | input | 16 | Per-line clear requests |
| lo_down | input | 1 | Low (or unified) counter is counting down |
| hi_down | input | 1 | High counter is counting down |
| lo_halt | input | 1 | Low counter is halted |
| hi_halt | input | 1 | High counter is halted |
| unify | input | 1 | Counters run as one wide counter |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Write rejected, same cycle |
| out_lines | output | 16 | Timer output lines |

## Verification
The hardest case to reach from the ports is a swap that depends on three things at once. The steering field has to be loaded first, the target line has to hold a known level, and then a single request has to arrive while the right down flag and unify value are present. Only then does the swapped result differ from the plain one. Directed sequences first load the line through a legal halted write and then program word 1. They then issue the lone request with each combination of flags, including the reserved field and field 2 under unify. A long run of seeded random cycles follows, mixing steering writes, illegal writes and crossed requests, and is compared every cycle against a bench model.

// File: rtl/tmr_outctl_pkg.sv
package tmr_outctl_pkg;
    localparam int unsigned DEF_LINES  = 16;
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_ADDR_W = 2;

    typedef enum logic [1:0] {
        SW_NONE = 2'd0,
        SW_LOW  = 2'd1,
        SW_HIGH = 2'd2,
        SW_RSVD = 2'd3
    } swap_mode_e;

    localparam logic [1:0] WORD_LINES = 2'd0;
    localparam logic [1:0] WORD_STEER = 2'd1;
endpackage

// File: rtl/tmr_swap_sel.sv
module tmr_swap_sel
    import tmr_outctl_pkg::*;
#(
    parameter int unsigned N_LINES = DEF_LINES,
    localparam int unsigned CFG_W  = 2 * N_LINES
) (
    input  logic [CFG_W-1:0]   steer_cfg,
    input  logic               lo_down,
    input  logic               hi_down,
    input  logic               unify,
    output logic [N_LINES-1:0] swap
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        swap_mode_e mode;
        assign mode = swap_mode_e'(steer_cfg[2*i +: 2]);
        always_comb begin
            unique case (mode)
                SW_NONE: swap[i] = 1'b0;
                SW_LOW:  swap[i] = lo_down;
                SW_HIGH: swap[i] = hi_down & ~unify;
                SW_RSVD: swap[i] = 1'b0;
                default: swap[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_out_bank.sv
module tmr_out_bank #(
    parameter int unsigned N_LINES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] set_eff,
    input  logic [N_LINES-1:0] clr_eff,
    input  logic               ld_en,
    input  logic [N_LINES-1:0] ld_val,
    output logic [N_LINES-1:0] lines_q
);
    logic [N_LINES-1:0] lines_d;

    always_comb begin
        for (int i = 0; i < N_LINES; i++) begin
            unique case ({set_eff[i], clr_eff[i]})
                2'b11:   lines_d[i] = ~lines_q[i];
                2'b10:   lines_d[i] = 1'b1;
                2'b01:   lines_d[i] = 1'b0;
                default: lines_d[i] = lines_q[i];
            endcase
        end
        if (ld_en) lines_d = ld_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lines_q <= '0;
        else        lines_q <= lines_d;
    end
endmodule

// File: rtl/tmr_out_regs.sv
module tmr_out_regs
    import tmr_outctl_pkg::*;
#(
    parameter int unsigned N_LINES = DEF_LINES,
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    localparam int unsigned CFG_W  = 2 * N_LINES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               both_halted,
    input  logic [N_LINES-1:0] lines_q,
    output logic [CFG_W-1:0]   steer_q,
    output logic               ld_en,
    output logic [N_LINES-1:0] ld_val,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err
);
    logic hit_lines, hit_steer;

    assign hit_lines = (bus_addr == ADDR_W'(WORD_LINES));
    assign hit_steer = (bus_addr == ADDR_W'(WORD_STEER));
    assign ld_en     = bus_wr & hit_lines & both_halted;
    assign ld_val    = bus_wdata[N_LINES-1:0];
    assign bus_err   = bus_wr & hit_lines & ~both_halted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 steer_q <= '0;
        else if (bus_wr && hit_steer) steer_q <= bus_wdata[CFG_W-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && hit_lines)      bus_rdata[N_LINES-1:0] = lines_q;
        else if (bus_rd && hit_steer) bus_rdata[CFG_W-1:0]   = steer_q;
    end
endmodule

// File: rtl/tmr_outctl.sv
module tmr_outctl
    import tmr_outctl_pkg::*;
#(
    parameter int unsigned N_LINES = DEF_LINES,
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned ADDR_W  = DEF_ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] ev_set,
    input  logic [N_LINES-1:0] ev_clr,
    input  logic               lo_down,
    input  logic               hi_down,
    input  logic               lo_halt,
    input  logic               hi_halt,
    input  logic               unify,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err,
    output logic [N_LINES-1:0] out_lines
);
    localparam int unsigned CFG_W = 2 * N_LINES;

    logic [CFG_W-1:0]   steer_q;
    logic [N_LINES-1:0] swap, set_eff, clr_eff, ld_val;
    logic               ld_en;

    tmr_out_regs #(.N_LINES(N_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .both_halted(lo_halt & hi_halt), .lines_q(out_lines),
        .steer_q(steer_q), .ld_en(ld_en), .ld_val(ld_val),
        .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    tmr_swap_sel #(.N_LINES(N_LINES)) u_swap (
        .steer_cfg(steer_q), .lo_down(lo_down), .hi_down(hi_down),
        .unify(unify), .swap(swap)
    );

    always_comb begin
        for (int i = 0; i < N_LINES; i++) begin
            set_eff[i] = swap[i] ? ev_clr[i] : ev_set[i];
            clr_eff[i] = swap[i] ? ev_set[i] : ev_clr[i];
        end
    end

    tmr_out_bank #(.N_LINES(N_LINES)) u_bank (
        .clk(clk), .rst_n(rst_n), .set_eff(set_eff), .clr_eff(clr_eff),
        .ld_en(ld_en), .ld_val(ld_val), .lines_q(out_lines)
    );
endmodule

// File: rtl/tmr_outctl_chk.sv
module tmr_outctl_chk #(
    parameter int unsigned N_LINES = 16,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINES-1:0] ev_set,
    input logic [N_LINES-1:0] ev_clr,
    input logic               lo_halt,
    input logic               hi_halt,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               bus_err,
    input logic [N_LINES-1:0] out_lines
);
    logic wr_lines;
    assign wr_lines = bus_wr && (bus_addr == '0);

    always_comb begin
        if (!rst_n) begin
            p_reset_clear_r1: assert (out_lines == '0);
        end
    end

    p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lines && ev_set == '0 && ev_clr == '0) |=> $stable(out_lines));

    p_toggle_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lines && (&ev_set) && (&ev_clr)) |=> (out_lines == ~$past(out_lines)));

    p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lines && lo_halt && hi_halt) |=> (out_lines == $past(bus_wdata[N_LINES-1:0])));

    p_err_only_running_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (wr_lines && !(lo_halt && hi_halt)));

    p_err_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && ev_set == '0 && ev_clr == '0) |=> $stable(out_lines));

    p_read_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == '0) |-> (bus_rdata[N_LINES-1:0] == out_lines
                                         && bus_rdata[DATA_W-1:N_LINES] == '0));

    p_idle_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

bind tmr_outctl tmr_outctl_chk #(.N_LINES(N_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .ev_clr(ev_clr),
    .lo_halt(lo_halt), .hi_halt(hi_halt), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .out_lines(out_lines)
);

// File: tb/sim_tmr_outctl.sv
module sim_tmr_outctl;
    localparam int CLK_P = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ev_set = '0, ev_clr = '0;
    logic        lo_down = 0, hi_down = 0, lo_halt = 1, hi_halt = 1, unify = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [15:0] out_lines;

    int n_cmp = 0, n_bad = 0;
    logic [15:0] m_out = '0;
    logic [31:0] m_steer = '0;

    always #(CLK_P/2) clk = ~clk;

    tmr_outctl u0 (
        .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .ev_clr(ev_clr),
        .lo_down(lo_down), .hi_down(hi_down), .lo_halt(lo_halt), .hi_halt(hi_halt),
        .unify(unify), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .out_lines(out_lines)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic f_swap(input logic [1:0] fld, input logic ld, input logic hd,
                                    input logic un);
        if (fld == 2'd1) return ld;
        if (fld == 2'd2) return hd & ~un;
        return 1'b0;
    endfunction

    function automatic logic [15:0] f_next(input logic [15:0] cur, input logic [31:0] st,
                                           input logic [15:0] s, input logic [15:0] c,
                                           input logic ld, input logic hd, input logic un);
        logic [15:0] r;
        for (int i = 0; i < N; i++) begin
            logic se, ce;
            se = f_swap(st[2*i +: 2], ld, hd, un) ? c[i] : s[i];
            ce = f_swap(st[2*i +: 2], ld, hd, un) ? s[i] : c[i];
            r[i] = (se && ce) ? ~cur[i] : se ? 1'b1 : ce ? 1'b0 : cur[i];
        end
        return r;
    endfunction

    function automatic logic [31:0] f_read(input logic rd, input logic [1:0] a);
        if (!rd) return 32'd0;
        if (a == 2'd0) return {16'd0, m_out};
        if (a == 2'd1) return m_steer;
        return 32'd0;
    endfunction

    // one cycle: inputs already driven at negedge; check comb outputs, clock, check lines
    task automatic cyc(input string tag);
        logic legal, bad;
        #1;
        legal = bus_wr && bus_addr == 2'd0 && lo_halt && hi_halt;
        bad   = bus_wr && bus_addr == 2'd0 && !(lo_halt && hi_halt);
        check({tag, " R8 err"}, {31'd0, bus_err}, {31'd0, bad});
        check({tag, " R9/R10/R11 rdata"}, bus_rdata, f_read(bus_rd, bus_addr));
        if (legal) m_out = bus_wdata[15:0];
        else       m_out = f_next(m_out, m_steer, ev_set, ev_clr, lo_down, hi_down, unify);
        if (bus_wr && bus_addr == 2'd1) m_steer = bus_wdata;
        @(negedge clk);
        check({tag, " lines"}, {16'd0, out_lines}, {16'd0, m_out});
    endtask

    task automatic quiet();
        ev_set = '0; ev_clr = '0; bus_wr = 0; bus_rd = 0; bus_addr = '0;
        lo_down = 0; hi_down = 0; unify = 0; lo_halt = 1; hi_halt = 1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
        quiet(); bus_wr = 1; bus_addr = a; bus_wdata = d; cyc(tag);
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        quiet(); bus_rd = 1; bus_addr = a; cyc(tag);
    endtask

    initial begin
        #(CLK_P*2000*40);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (2) @(negedge clk);
        check("R1 reset lines", {16'd0, out_lines}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        rd(2'd0, "R1 read lines");
        rd(2'd1, "R1 read steer");
        check("R1 steer zero", bus_rdata, 32'd0);

        // R10 steering readback with distinct fields
        wr(2'd1, 32'hE4E4_1B1B, "R10 write");
        rd(2'd1, "R10 read");
        wr(2'd1, 32'd0, "R10 clear");

        // R2 plain set then clear
        quiet(); ev_set = 16'h0008; cyc("R2 set");
        check("R2 line3 high", {31'd0, out_lines[3]}, 32'd1);
        quiet(); ev_clr = 16'h0008; cyc("R2 clr");
        check("R2 line3 low", {31'd0, out_lines[3]}, 32'd0);

        // R3 field 1 swap with lo_down: line0 high, set request clears it
        wr(2'd0, 32'h0001, "R7 preload");
        wr(2'd1, 32'h0000_0001, "R3 cfg");
        quiet(); lo_down = 1; unify = 1; ev_set = 16'h0001; cyc("R3 swap");
        check("R3 set acts as clear", {31'd0, out_lines[0]}, 32'd0);

        // R4 field 2 swap with hi_down
        wr(2'd0, 32'h0002, "R7 preload");
        wr(2'd1, 32'h0000_0008, "R4 cfg");
        quiet(); hi_down = 1; ev_set = 16'h0002; cyc("R4 swap");
        check("R4 set acts as clear", {31'd0, out_lines[1]}, 32'd0);

        // R5 field 2 under unify: no swap
        quiet(); hi_down = 1; unify = 1; ev_set = 16'h0002; cyc("R5 unify");
        check("R5 field2 unify no swap", {31'd0, out_lines[1]}, 32'd1);
        // R5 field 3: no swap
        wr(2'd1, 32'h0000_0030, "R5 cfg");
        quiet(); lo_down = 1; hi_down = 1; ev_clr = 16'h0004; ev_set = 16'h0000; cyc("R5 rsvd");
        check("R5 field3 clear stays clear", {31'd0, out_lines[2]}, 32'd0);
        quiet(); lo_down = 1; hi_down = 1; ev_set = 16'h0004; cyc("R5 rsvd set");
        check("R5 field3 set", {31'd0, out_lines[2]}, 32'd1);

        // R6 toggle
        wr(2'd0, 32'h00F0, "R7 preload");
        quiet(); ev_set = 16'h0FF0; ev_clr = 16'h0FF0; cyc("R6 toggle");
        check("R6 toggled", {16'd0, out_lines}, 32'h0F00);

        // R7 priority over events
        quiet(); bus_wr = 1; bus_addr = 0; bus_wdata = 32'hFFFF_A5C3;
        ev_set = 16'hFFFF; cyc("R7 prio");
        check("R7 load wins", {16'd0, out_lines}, 32'hA5C3);

        // R8 illegal write
        quiet(); lo_halt = 0; bus_wr = 1; bus_addr = 0; bus_wdata = 32'h0; #1;
        check("R8 err raised", {31'd0, bus_err}, 32'd1);
        cyc("R8 blocked");
        check("R8 unchanged", {16'd0, out_lines}, 32'hA5C3);

        // R9 read while running
        quiet(); hi_halt = 0; bus_rd = 1; bus_addr = 0; #1;
        check("R9 upper zero", {16'd0, bus_rdata[31:16]}, 32'd0);
        cyc("R9 read");

        // R11 unmapped address
        wr(2'd2, 32'hFFFF_FFFF, "R11 write");
        rd(2'd3, "R11 read");
        rd(2'd1, "R11 steer kept");

        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            r = $urandom;
            ev_set = 16'($urandom); ev_clr = 16'($urandom);
            if (r[3:0] < 4) ev_set = ev_set & ev_clr;
            lo_down = r[4]; hi_down = r[5]; unify = r[6];
            lo_halt = r[7] | r[8]; hi_halt = r[9] | r[10];
            bus_wr = (r[13:11] == 0); bus_rd = r[14];
            bus_addr = r[16:15]; bus_wdata = $urandom;
            cyc("R2/R3/R4/R5/R6 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule